// File: doc/BRIEF.md
# Speculative-Commit Reorder Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. Each cycle it can take one newly issued instruction and give it a slot at the tail of a circular queue. The slot index is returned as the instruction's tag. The slot stores the destination register, the operation class and, for a store, the memory address. Execution results come back on a shared result bus in any order. Each result is matched to its slot by tag and marks that slot complete. For a branch, the result also carries a mispredict flag.

Retirement happens only at the head, at most one entry per cycle:

- A register-writing entry drives the register-file write port.
- A store drives the memory write port. Its data is the value that came back on the result bus.
- A correctly predicted branch retires silently.
- A mispredicted branch raises `flush_o` and discards every younger entry. After the flush, allocation restarts just past the branch.

Nothing leaves the block before reaching the head, so work done down a wrong path never reaches architectural state.

Top module: `spec_rob`

## Requirements
- R1: An accepted dispatch (`disp_valid_i` high, `full_o` low, no flush that cycle) takes the slot whose index is shown on `disp_tag_o` in that cycle. The tag then advances by one, modulo the depth (8 by default), so tags follow program order.
- R2: `full_o` is high exactly when all 8 slots are occupied. A dispatch presented while full is ignored and does not overwrite any entry.
- R3: After reset, and whenever no slot is occupied, `empty_o` is high and `reg_we_o`, `st_valid_o` and `flush_o` are all low.
- R4: Entries retire only from the head, one per cycle, in dispatch order. An entry retires only once its result has arrived.
- R5: An incomplete head entry blocks every retirement, even when younger entries are already complete.
- R6: Operation class 0 (register op) retires with `reg_we_o` high. `reg_dest_o` carries its destination and `reg_value_o` carries its result value.
- R7: Operation class 1 (store) retires with `st_valid_o` high and `reg_we_o` low. `st_addr_o` carries the dispatch-time address and `st_data_o` carries the result-bus value.
- R8: Operation class 2 (branch) whose result has `res_mispred_i` low retires with no write and no flush. Younger entries stay valid and retire afterwards.
- R9: A branch whose result has `res_mispred_i` high raises `flush_o` while it retires. In the next cycle the buffer is empty, and `disp_tag_o` equals the branch tag plus one.
- R10: A result whose tag names an unoccupied slot is ignored.
- R11: A dispatch and a retirement in the same cycle both take effect. A dispatch in the cycle of a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_kind_i | input | 2 | Operation class: 0 register op, 1 store, 2 branch |
| disp_dest_i | input | REG_W | Destination register |
| disp_addr_i | input | ADDR_W | Store address |
| disp_tag_o | output | TAG_W | Tag given to the current dispatch |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |
| res_valid_i | input | 1 | Result bus valid |
| res_tag_i | input | TAG_W | Result tag |
| res_value_i | input | DATA_W | Result value or store data |
| res_mispred_i | input | 1 | Branch outcome differs from prediction |
| reg_we_o | output | 1 | Register write on retirement |
| reg_dest_o | output | REG_W | Register write index |
| reg_value_o | output | DATA_W | Register write data |
| st_valid_o | output | 1 | Store write on retirement |
| st_addr_o | output | ADDR_W | Store address |
| st_data_o | output | DATA_W | Store data |
| flush_o | output | 1 | Mispredicted branch retiring; younger work discarded |

## Verification
The assertions assume each tag appears on the result bus at most once per allocation. They also assume a result only arrives for an entry that was already dispatched, except for the deliberate stale tag. The stimulus follows this by sending a single result per dispatched tag. It sends one stray result, only into a flushed slot, and sends it before that slot is reused. Results never arrive in the same cycle as the dispatch of their own tag. At most one result, and therefore one branch resolution, is sent per cycle.

// File: rtl/spec_rob_pkg.sv
package spec_rob_pkg;
  typedef enum logic [1:0] {
    KIND_ALU    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/spec_rob_ptrs.sv
// Head/tail/occupancy control. DEPTH must be a power of two.
module spec_rob_ptrs #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flush_i,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_o  <= '0;
      tail_o  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      // flush coincides with the branch retiring: restart just past it
      head_o  <= head_o + 1'b1;
      tail_o  <= head_o + 1'b1;
      count_q <= '0;
    end else begin
      if (push_i) tail_o <= tail_o + 1'b1;
      if (pop_i)  head_o <= head_o + 1'b1;
      count_q <= count_q + CNT_W'(push_i) - CNT_W'(pop_i);
    end
  end

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);

  a_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  a_r2_push_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r3_pop_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  a_r1_tail_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !flush_i) |=> tail_o == TAG_W'($past(tail_o) + 1'b1));
  a_r9_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (empty_o && head_o == tail_o));
endmodule

// File: rtl/spec_rob_slot.sv
module spec_rob_slot
  import spec_rob_pkg::*;
#(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  rob_kind_e         kind_i,
  input  logic [REG_W-1:0]  dest_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              res_hit_i,
  input  logic [DATA_W-1:0] res_value_i,
  input  logic              res_mispred_i,
  input  logic              retire_i,
  input  logic              kill_i,
  output logic              valid_o,
  output logic              done_o,
  output logic              mispred_o,
  output rob_kind_e         kind_o,
  output logic [REG_W-1:0]  dest_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] value_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      done_o    <= 1'b0;
      mispred_o <= 1'b0;
      kind_o    <= KIND_ALU;
      dest_o    <= '0;
      addr_o    <= '0;
      value_o   <= '0;
    end else if (kill_i) begin
      valid_o <= 1'b0;
      done_o  <= 1'b0;
    end else if (alloc_i) begin
      valid_o   <= 1'b1;
      done_o    <= 1'b0;
      mispred_o <= 1'b0;
      kind_o    <= kind_i;
      dest_o    <= dest_i;
      addr_o    <= addr_i;
    end else begin
      if (retire_i) begin
        valid_o <= 1'b0;
        done_o  <= 1'b0;
      end else if (res_hit_i) begin
        done_o    <= 1'b1;
        value_o   <= res_value_i;
        mispred_o <= res_mispred_i;
      end
    end
  end

  a_r4_retire_complete: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retire_i |-> (valid_o && done_o));
  a_r10_hit_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_hit_i |-> valid_o);
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import spec_rob_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned TAG_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              disp_valid_i,
  input  logic [1:0]        disp_kind_i,
  input  logic [REG_W-1:0]  disp_dest_i,
  input  logic [ADDR_W-1:0] disp_addr_i,
  output logic [TAG_W-1:0]  disp_tag_o,
  output logic              full_o,
  output logic              empty_o,
  input  logic              res_valid_i,
  input  logic [TAG_W-1:0]  res_tag_i,
  input  logic [DATA_W-1:0] res_value_i,
  input  logic              res_mispred_i,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_dest_o,
  output logic [DATA_W-1:0] reg_value_o,
  output logic              st_valid_o,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o,
  output logic              flush_o
);
  logic [TAG_W-1:0]  head, tail;
  logic              push, pop, flush;
  logic [DEPTH-1:0]  s_valid, s_done, s_mispred;
  rob_kind_e         s_kind  [DEPTH];
  logic [REG_W-1:0]  s_dest  [DEPTH];
  logic [ADDR_W-1:0] s_addr  [DEPTH];
  logic [DATA_W-1:0] s_value [DEPTH];

  assign pop   = !empty_o && s_done[head];
  assign flush = pop && (s_kind[head] == KIND_BRANCH) && s_mispred[head];
  assign push  = disp_valid_i && !full_o && !flush;

  spec_rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i, .rst_ni,
    .push_i(push), .pop_i(pop), .flush_i(flush),
    .head_o(head), .tail_o(tail), .full_o, .empty_o
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    spec_rob_slot #(.REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_slot (
      .clk_i, .rst_ni,
      .alloc_i      (push && tail == TAG_W'(i)),
      .kind_i       (rob_kind_e'(disp_kind_i)),
      .dest_i       (disp_dest_i),
      .addr_i       (disp_addr_i),
      .res_hit_i    (res_valid_i && res_tag_i == TAG_W'(i) && s_valid[i]),
      .res_value_i  (res_value_i),
      .res_mispred_i(res_mispred_i),
      .retire_i     (pop && head == TAG_W'(i)),
      .kill_i       (flush),
      .valid_o      (s_valid[i]),
      .done_o       (s_done[i]),
      .mispred_o    (s_mispred[i]),
      .kind_o       (s_kind[i]),
      .dest_o       (s_dest[i]),
      .addr_o       (s_addr[i]),
      .value_o      (s_value[i])
    );
  end

  assign disp_tag_o  = tail;
  assign reg_we_o    = pop && (s_kind[head] == KIND_ALU);
  assign reg_dest_o  = s_dest[head];
  assign reg_value_o = s_value[head];
  assign st_valid_o  = pop && (s_kind[head] == KIND_STORE);
  assign st_addr_o   = s_addr[head];
  assign st_data_o   = s_value[head];
  assign flush_o     = flush;

  a_r3_empty_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !(reg_we_o || st_valid_o || flush_o));
  a_r4_single_retire: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, st_valid_o, flush_o}));
  a_r5_head_occupied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> s_valid[head]);
  a_r11_flush_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> empty_o);
endmodule

// File: tb/sim_spec_rob.sv
`timescale 1ns/1ps
module sim_spec_rob;
  localparam int DEPTH = 8, REG_W = 5, ADDR_W = 16, DATA_W = 16, TAG_W = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic disp_valid_i = 0; logic [1:0] disp_kind_i = 0;
  logic [REG_W-1:0] disp_dest_i = 0; logic [ADDR_W-1:0] disp_addr_i = 0;
  logic res_valid_i = 0; logic [TAG_W-1:0] res_tag_i = 0;
  logic [DATA_W-1:0] res_value_i = 0; logic res_mispred_i = 0;
  logic [TAG_W-1:0] disp_tag_o; logic full_o, empty_o, reg_we_o, st_valid_o, flush_o;
  logic [REG_W-1:0] reg_dest_o; logic [DATA_W-1:0] reg_value_o, st_data_o;
  logic [ADDR_W-1:0] st_addr_o;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  spec_rob #(.DEPTH(DEPTH), .REG_W(REG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni, .disp_valid_i, .disp_kind_i, .disp_dest_i, .disp_addr_i,
    .disp_tag_o, .full_o, .empty_o, .res_valid_i, .res_tag_i, .res_value_i,
    .res_mispred_i, .reg_we_o, .reg_dest_o, .reg_value_o, .st_valid_o,
    .st_addr_o, .st_data_o, .flush_o);

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance to next cycle: drive at negedge, outputs settle by #1.
  task automatic nxt();
    @(negedge clk);
    disp_valid_i = 0; res_valid_i = 0; res_mispred_i = 0;
  endtask

  task automatic set_disp(int kind, int dest, int addr);
    disp_valid_i = 1; disp_kind_i = 2'(kind);
    disp_dest_i = REG_W'(dest); disp_addr_i = ADDR_W'(addr);
  endtask

  task automatic set_res(int tag, int val, bit mis);
    res_valid_i = 1; res_tag_i = TAG_W'(tag);
    res_value_i = DATA_W'(val); res_mispred_i = mis;
  endtask

  task automatic quiet(string req);
    chk({req, " reg_we"}, reg_we_o, 0);
    chk({req, " st_valid"}, st_valid_o, 0);
    chk({req, " flush"}, flush_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    #1;
    // R3 reset state
    chk("R3 empty", empty_o, 1); chk("R3 full", full_o, 0);
    chk("R1 tag", disp_tag_o, 0); quiet("R3");

    // R1/R2 fill all slots with register ops, dest = tag+1
    for (int i = 0; i < DEPTH; i++) begin
      nxt(); set_disp(0, i + 1, 0); #1;
      chk("R1 tag order", disp_tag_o, i);
      chk("R2 not full", full_o, 0);
    end
    nxt(); #1;
    chk("R2 full", full_o, 1); chk("R3 not empty", empty_o, 0);
    // R2 dispatch while full is ignored
    set_disp(0, 31, 0);
    nxt(); #1; chk("R2 still full", full_o, 1);

    // R5 complete younger entries in reverse order, head blocks
    for (int t = DEPTH - 1; t >= 1; t--) begin
      set_res(t, 100 + t, 0); #1;
      quiet("R5 blocked");
      nxt(); #1;
    end
    quiet("R5 blocked");
    set_res(0, 100, 0);
    nxt(); #1;
    // R4/R6 retire in order, one per cycle
    for (int k = 0; k < DEPTH; k++) begin
      chk("R6 reg_we", reg_we_o, 1);
      chk("R6 dest", reg_dest_o, k + 1);
      chk("R4 value order", reg_value_o, 100 + k);
      nxt(); #1;
    end
    chk("R3 empty after drain", empty_o, 1); quiet("R3");

    // R7 store at tag 0, R11 dispatch during retirement
    set_disp(1, 0, 16'h4A0); #1; chk("R1 store tag", disp_tag_o, 0);
    nxt(); set_res(0, 16'hAB, 0);
    nxt(); set_disp(0, 9, 0); #1;
    chk("R7 st_valid", st_valid_o, 1); chk("R7 no reg_we", reg_we_o, 0);
    chk("R7 addr", st_addr_o, 16'h4A0); chk("R7 data", st_data_o, 16'hAB);
    chk("R11 tag with retire", disp_tag_o, 1);
    nxt(); #1;
    chk("R11 both applied", empty_o, 0);
    set_res(1, 55, 0);
    nxt(); #1;
    chk("R11 reg_we", reg_we_o, 1); chk("R11 dest", reg_dest_o, 9);
    chk("R11 value", reg_value_o, 55);
    nxt(); #1; chk("R11 empty", empty_o, 1);

    // R8 correctly predicted branch tag 2, younger op tag 3
    set_disp(2, 0, 0); #1; chk("R1 branch tag", disp_tag_o, 2);
    nxt(); set_disp(0, 3, 0);
    nxt(); set_res(3, 77, 0);
    nxt(); set_res(2, 0, 0);
    nxt(); #1;
    quiet("R8 branch retire"); chk("R8 not empty", empty_o, 0);
    nxt(); #1;
    chk("R8 younger kept", reg_we_o, 1); chk("R8 dest", reg_dest_o, 3);
    chk("R8 value", reg_value_o, 77);
    nxt(); #1; chk("R8 empty", empty_o, 1);

    // R9 mispredicted branch tag 4, younger 5 and 6
    set_disp(2, 0, 0); #1; chk("R1 branch tag", disp_tag_o, 4);
    nxt(); set_disp(0, 5, 0);
    nxt(); set_disp(0, 6, 0);
    nxt(); set_res(6, 66, 0);
    nxt(); set_res(4, 0, 1);
    nxt(); set_disp(0, 20, 0); #1;
    chk("R9 flush", flush_o, 1); chk("R9 no write", reg_we_o, 0);
    nxt(); #1;
    chk("R9 empty after flush", empty_o, 1);
    chk("R11 dispatch dropped", disp_tag_o, 5);
    // R10 stale result into flushed slot 6
    set_res(6, 99, 0);
    nxt(); #1;
    chk("R10 stays empty", empty_o, 1); quiet("R10");
    set_disp(0, 7, 0); #1; chk("R9 restart tag", disp_tag_o, 5);
    nxt(); #1; quiet("R5 new head incomplete");
    set_res(5, 9, 0);
    nxt(); #1;
    chk("R6 reg_we", reg_we_o, 1); chk("R6 dest", reg_dest_o, 7);
    chk("R6 value", reg_value_o, 9);
    nxt(); #1; chk("R3 final empty", empty_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule